// File: doc/BRIEF.md
# Machine State Register Write Unit

This block keeps a 64-bit machine state register. Bits are numbered big-endian: index 0 is the most significant bit. All ports and internal vectors are declared `[0:63]`, so an index in the text is the same as an index in the code.

A single write strobe applies a source operand to the register. Two inputs control the write:

- The form select picks either a narrow write, which touches only the lower word, or a wide write, which can also reach the upper word.
- The L flag reduces the write to two bits.

Many bits do not take a plain copy of the source:

- Source bit 49 forces three other bits to one.
- A few bits are never writable.
- The three-bit field at 29–31 refuses one particular transition.

The whole register is always visible on a combinational read port. Reset loads a parameterised value.

Top module: `msr_write_unit`

## Requirements
- R1: With `wr_en`=1 and `l_flag`=1, only bits 48 and 62 take the source value; every other bit keeps its value, in either form.
- R2: With `wr_en`=1 and `l_flag`=0, bits 48, 58 and 59 each become the OR of their own source bit and source bit 49.
- R3: With `wr_en`=1 and `l_flag`=0, bits 32–40, 42–47, 49–50, 52–57 and 60–62 copy the source, in either form.
- R4: Bits 3, 41, 51 and 63 never change after reset.
- R5: A wide write (`wide_form`=1) with `l_flag`=0 copies source bits 0–2 and 4–28.
- R6: In a wide write with `l_flag`=0, bits 29–31 take the source value, except when the current value is 010 and the source value is 000; in that case the field keeps 010.
- R7: A narrow write (`wide_form`=0) never changes bits 0–31.
- R8: Without `wr_en` the register holds its value. While `rst_n` is low the register loads `RESET_VALUE`. `msr_out` always shows the full register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wide_form | input | 1 | 1 = wide write (reaches bits 0–31), 0 = narrow write |
| l_flag | input | 1 | 1 = write only bits 48 and 62 |
| src_op | input | 64 | Source operand, index 0 is the MSB |
| msr_out | output | 64 | Current register contents |

## Verification
Two rules can fall in the same cycle: the bit-49 forcing and the guarded update of bits 29–31. Both act in a wide write with the L flag clear. The bench provokes this in two ways:

- A directed write whose source has only bit 49 set, issued while the field holds 010.
- Random operands, with that field biased toward 000 and 010 so the guard case comes up often.

Each result is judged bit by bit against a model in the bench. The model is written from the requirements. It confirms that the field held 010 while bits 48, 58 and 59 turned on in the same write.

// File: rtl/msr_write_unit.sv
module msr_write_unit #(
  parameter logic [0:63] RESET_VALUE = 64'h1000_0002_0040_1001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wide_form,
  input  logic        l_flag,
  input  logic [0:63] src_op,
  output logic [0:63] msr_out
);

  function automatic logic [0:63] span(input int lo, input int hi);
    logic [0:63] m;
    m = '0;
    for (int k = 0; k < 64; k++)
      if (k >= lo && k <= hi) m[k] = 1'b1;
    return m;
  endfunction

  localparam logic [0:63] LOW_COPY  = span(32, 40) | span(42, 47) | span(49, 50)
                                    | span(52, 57) | span(60, 62);
  localparam logic [0:63] HIGH_COPY = span(0, 2) | span(4, 28);

  logic [0:63] msr_q, nxt, copy_mask;
  logic        keep_state;

  assign copy_mask  = LOW_COPY | (wide_form ? HIGH_COPY : 64'd0);
  assign keep_state = (msr_q[29:31] == 3'b010) && (src_op[29:31] == 3'b000);

  always_comb begin
    nxt = msr_q;
    if (l_flag) begin
      nxt[48] = src_op[48];
      nxt[62] = src_op[62];
    end else begin
      nxt = (msr_q & ~copy_mask) | (src_op & copy_mask);
      nxt[48] = src_op[48] | src_op[49];
      nxt[58] = src_op[58] | src_op[49];
      nxt[59] = src_op[59] | src_op[49];
      if (wide_form && !keep_state) nxt[29:31] = src_op[29:31];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     msr_q <= RESET_VALUE;
    else if (wr_en) msr_q <= nxt;
  end

  assign msr_out = msr_q;

  AST_L_TWO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && l_flag |=> msr_q[48] == $past(src_op[48]) && msr_q[62] == $past(src_op[62])); // R1
  AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !l_flag && src_op[49] |=> msr_q[48] && msr_q[58] && msr_q[59]); // R2
  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> msr_q[3] == $past(msr_q[3]) && msr_q[41] == $past(msr_q[41])
          && msr_q[51] == $past(msr_q[51]) && msr_q[63] == $past(msr_q[63])); // R4
  AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wide_form && !l_flag && msr_q[29:31] == 3'b010 && src_op[29:31] == 3'b000
    |=> msr_q[29:31] == 3'b010); // R6
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wide_form |=> msr_q[0:31] == $past(msr_q[0:31])); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(msr_q)); // R8

endmodule

// File: tb/test_msr_write_unit.sv
module test_msr_write_unit;
  localparam logic [0:63] RV = 64'h1000_0002_0040_1001;

  logic clk = 0, rst_n = 0, wr_en = 0, wide_form = 0, l_flag = 0;
  logic [0:63] src_op = '0, msr_out, model;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  msr_write_unit #(.RESET_VALUE(RV)) i_msr_write_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wide_form(wide_form),
    .l_flag(l_flag), .src_op(src_op), .msr_out(msr_out));

  function automatic logic [0:63] expect_next(logic [0:63] cur, logic [0:63] s, logic l, logic w);
    logic [0:63] r;
    r = cur;
    for (int k = 0; k < 64; k++) begin
      if (l) begin
        if (k == 48 || k == 62) r[k] = s[k];
      end else if (k == 48 || k == 58 || k == 59) r[k] = s[k] | s[49];
      else if (k == 3 || k == 41 || k == 51 || k == 63) r[k] = cur[k];
      else if (k >= 32) r[k] = s[k];
      else if (w && k <= 28) r[k] = s[k];
    end
    if (!l && w && !(cur[29:31] == 3'b010 && s[29:31] == 3'b000)) r[29:31] = s[29:31];
    return r;
  endfunction

  task automatic check(string req, logic [0:63] exp);
    total++;
    if (msr_out !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, msr_out, exp);
    end
  endtask

  task automatic apply(logic en, logic [0:63] s, logic l, logic w, string req);
    @(negedge clk);
    wr_en = en; src_op = s; l_flag = l; wide_form = w;
    if (en) model = expect_next(model, s, l, w);
    @(negedge clk);
    wr_en = 0;
    check(req, model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model = RV;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset value", RV);

    apply(1, 64'd0, 0, 1, "R6 guard 010 vs source 000");
    apply(1, 64'h0000_0000_0000_4000, 0, 1, "R2 R6 forcing plus guard");
    apply(1, '1, 1, 1, "R1 L flag wide");
    apply(1, 64'd0, 1, 0, "R1 L flag narrow");
    apply(1, '1, 0, 0, "R3 R7 narrow all ones");
    apply(1, '1, 0, 1, "R5 R4 wide all ones");
    apply(1, 64'd0, 0, 1, "R6 field 111 to 000");
    apply(0, '1, 0, 1, "R8 no strobe");
    apply(1, 64'h0000_0000_0000_0000, 0, 0, "R7 narrow zeros");

    for (int i = 0; i < 600; i++) begin
      logic [0:63] s;
      s = {$urandom, $urandom};
      if ($urandom_range(0, 1)) s[29:31] = $urandom_range(0, 1) ? 3'b000 : 3'b010;
      apply($urandom_range(0, 7) != 0, s, $urandom_range(0, 3) == 0,
            $urandom_range(0, 1), "R1 R2 R3 R5 R6 R7 random");
    end

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    model = RV;
    check("R8 reset again", RV);
    check("R4 fixed bits", RV);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule